// File: doc/BRIEF.md
# Lockable Idle-Start Watchdog Timer

This block is a down-counting supervision timer for a small 8-bit controller. The counter is built from two stages: an 8-bit low stage and a 6-bit high stage. Together they hold a 14-bit value, and every reload sets that value to all ones. The timer does nothing until software first writes its control register. From then on every write restarts the count from the top. If software stops writing, the counter runs out and the block asks the chip for an internal reset.

A select bit chooses how the count advances:
- **Cascaded:** each count-enable pulse steps the low stage, and a borrow from the low stage steps the high stage.
- **Direct:** the low stage is bypassed and each enable steps the high stage, so the timeout is 256 times shorter.

A second bit can only be set. Once it is 1, a stop-instruction execution reported by the core is treated as a fault and also raises the reset request.

The enable input comes from an external divider that runs at the system clock divided by 8. The reset request is a registered pulse of fixed length. While the pulse is high, every register of the block returns to its reset state and stays there.

Top module: `wdt_lock_top`

## Requirements
- R1: After `rst_n` is released, `rst_req` is 0 and `reg_rdata` reads 0x3F: high stage all ones, lock bit 0, source bit 0.
- R2: Before the first register write, count-enable pulses leave the high stage (`reg_rdata[5:0]`) unchanged and never raise `rst_req`.
- R3: Any register write, whatever its data, reloads the counter with 0x3FFF and starts counting from the next enable.
- R4: With `reg_rdata[7]` = 0 (cascaded), the high stage drops by one every 256 enables. The 16384th enable after a write raises `rst_req`.
- R5: With `reg_rdata[7]` = 1 (direct), the high stage drops by one on each enable. The 64th enable after a write raises `rst_req`.
- R6: `reg_rdata` carries the high stage in bits 5:0, the stop-lock bit in bit 6 and the count-source bit in bit 7. A write copies `reg_wdata[7]` into bit 7 and ORs `reg_wdata[6]` into bit 6.
- R7: Once the lock bit is 1, writing 0 to `reg_wdata[6]` leaves it at 1. Only a reset request or `rst_n` clears it.
- R8: A `stop_exec` pulse while the lock bit is 1 raises `rst_req` at the next edge. With the lock bit at 0 it has no effect.
- R9: `rst_req` stays high for exactly PULSE_LEN (4) cycles. From its first high cycle onward, all registers read back their reset state and the timer is idle again.
- R10: A write and an enable in the same cycle act as the write alone: the counter holds 0x3FFF after that edge.
- R11: Register writes made while `rst_req` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Single-cycle count-enable pulse from the external divider |
| stop_exec | input | 1 | Pulse: the core executed a stop instruction |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| rst_req | output | 1 | Internal reset request pulse |

## Verification
The hardest state to reach from the ports is a natural underflow in cascaded mode. It needs 16384 enables after the last write, with the high stage passing through every borrow from the low stage. The bench holds `cnt_en` high on every cycle and samples the readback at the 255/256 enable boundary and again one enable before the timeout. It then confirms that the request appears on the next enable. The reset pulse window is reached from both causes: direct-mode underflow and a locked stop. Writes are issued inside that window to show they are ignored.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   // Count source of the high stage.
   typedef enum logic {
      SRC_CASCADE = 1'b0,
      SRC_DIRECT  = 1'b1
   } wdt_src_e;

   // Cause of a reset request.
   typedef struct packed {
      logic underflow;
      logic locked_stop;
   } wdt_cause_t;

endpackage

// File: rtl/wdt_down_stage.sv
module wdt_down_stage #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic         dec,
   output logic [W-1:0] cnt,
   output logic         zero
);

   if (W < 1) begin : g_bad_w
      $error("wdt_down_stage: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '1;
      else if (clr || load) cnt <= '1;
      else if (dec)         cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

   // A borrow out of this stage wraps it back to all ones (R4).
   assert_stage_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && zero && !clr && !load) |=> (cnt == '1));

   // A plain step lowers the value by exactly one (R4, R5).
   assert_stage_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !zero && !clr && !load) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
   import wdt_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     clr,
   input  logic     wr,
   input  logic     wr_lock,
   input  logic     wr_src,
   output logic     armed,
   output logic     lock,
   output wdt_src_e src
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         lock  <= 1'b0;
         src   <= SRC_CASCADE;
      end else if (clr) begin
         armed <= 1'b0;
         lock  <= 1'b0;
         src   <= SRC_CASCADE;
      end else if (wr) begin
         armed <= 1'b1;
         lock  <= lock | wr_lock;
         src   <= wr_src ? SRC_DIRECT : SRC_CASCADE;
      end
   end

   // The lock bit never falls except through a clear (R7).
   assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && !clr) |=> lock);

   // Once running, the timer stays running until a clear (R3).
   assert_armed_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !clr) |=> armed);

endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen #(
   parameter int PULSE_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic pulse
);

   if (PULSE_LEN < 1) begin : g_bad_len
      $error("wdt_pulse_gen: PULSE_LEN must be at least 1");
   end

   if (PULSE_LEN == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pulse <= 1'b0;
         else        pulse <= fire && !pulse;
      end
   end else begin : g_stretch
      localparam int CW = $clog2(PULSE_LEN + 1);
      logic [CW-1:0] left;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              left <= '0;
         else if (left != '0)     left <= left - 1'b1;
         else if (fire)           left <= CW'(PULSE_LEN);
      end
      assign pulse = (left != '0);

      // The remaining length never exceeds the configured length (R9).
      assert_pulse_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
         left <= CW'(PULSE_LEN));
   end

   // A fire request with the pulse idle always starts a pulse (R9).
   assert_pulse_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !pulse) |=> pulse);

endmodule

// File: rtl/wdt_lock_top.sv
module wdt_lock_top
   import wdt_pkg::*;
#(
   parameter int LO_W      = 8,
   parameter int HI_W      = 6,
   parameter int DATA_W    = 8,
   parameter int PULSE_LEN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_en,
   input  logic              stop_exec,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              rst_req
);

   localparam int LOCK_POS = HI_W;
   localparam int SRC_POS  = HI_W + 1;

   if (SRC_POS >= DATA_W) begin : g_bad_map
      $error("wdt_lock_top: HI_W + 2 must not exceed DATA_W");
   end
   if (LO_W < 1 || HI_W < 1) begin : g_bad_stage
      $error("wdt_lock_top: stage widths must be positive");
   end

   logic            armed, lock;
   wdt_src_e        src;
   logic [LO_W-1:0] lo_cnt;
   logic [HI_W-1:0] hi_cnt;
   logic            lo_zero, hi_zero;
   logic            busy, clr, wr_ok, tick, step_lo, step_hi;
   wdt_cause_t      cause;

   assign busy    = rst_req;
   assign tick    = armed && cnt_en && !reg_we && !busy;
   assign step_lo = tick && (src == SRC_CASCADE);
   assign step_hi = tick && ((src == SRC_DIRECT) || lo_zero);

   assign cause.underflow   = step_hi && hi_zero;
   assign cause.locked_stop = stop_exec && lock && !busy;

   assign clr   = cause.underflow || cause.locked_stop || busy;
   assign wr_ok = reg_we && !clr;

   logic unused_wdata;
   assign unused_wdata = ^reg_wdata[HI_W-1:0];

   wdt_ctrl_reg u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .wr      (wr_ok),
      .wr_lock (reg_wdata[LOCK_POS]),
      .wr_src  (reg_wdata[SRC_POS]),
      .armed   (armed),
      .lock    (lock),
      .src     (src)
   );

   wdt_down_stage #(.W(LO_W)) u_lo (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .load  (wr_ok),
      .dec   (step_lo),
      .cnt   (lo_cnt),
      .zero  (lo_zero)
   );

   wdt_down_stage #(.W(HI_W)) u_hi (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .load  (wr_ok),
      .dec   (step_hi),
      .cnt   (hi_cnt),
      .zero  (hi_zero)
   );

   wdt_pulse_gen #(.PULSE_LEN(PULSE_LEN)) u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (|cause),
      .pulse (rst_req)
   );

   always_comb begin
      reg_rdata           = '0;
      reg_rdata[HI_W-1:0] = hi_cnt;
      reg_rdata[LOCK_POS] = lock;
      reg_rdata[SRC_POS]  = (src == SRC_DIRECT);
   end

   // Idle timer: enables do not move the counter (R2).
   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !reg_we && !busy) |=> ($stable(hi_cnt) && $stable(lo_cnt)));

   // An accepted write reloads all ones and arms the timer (R3, R10).
   assert_write_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && !busy && !cause.locked_stop) |=> (armed && hi_cnt == '1 && lo_cnt == '1));

   // Direct mode leaves the low stage untouched (R5).
   assert_direct_lo_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && src == SRC_DIRECT && !reg_we && !clr) |=> $stable(lo_cnt));

   // A locked stop request always produces a reset pulse (R8).
   assert_locked_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_exec && lock) |=> rst_req);

   // During the pulse every register is in its reset state (R9, R11).
   assert_pulse_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (!armed && !lock && src == SRC_CASCADE && hi_cnt == '1 && lo_cnt == '1));

endmodule

// File: tb/wdt_lock_top_test.sv
module wdt_lock_top_test;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 20;
   localparam int LIMIT      = 200000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cnt_en = 1'b0;
   logic       stop_exec = 1'b0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       rst_req;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wdt_lock_top uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_en    (cnt_en),
      .stop_exec (stop_exec),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .rst_req   (rst_req)
   );

   // Row: we, wdata[7:0], en, stop, exp_rdata[7:0], exp_rst
   localparam logic [19:0] VEC [NVEC] = '{
      {1'b0, 8'h00, 1'b1, 1'b0, 8'h3F, 1'b0},   // R2 idle
      {1'b0, 8'h00, 1'b1, 1'b0, 8'h3F, 1'b0},   // R2 idle
      {1'b1, 8'h80, 1'b0, 1'b0, 8'hBF, 1'b0},   // R3 R6 direct mode
      {1'b0, 8'h00, 1'b1, 1'b0, 8'hBE, 1'b0},   // R5
      {1'b0, 8'h00, 1'b1, 1'b0, 8'hBD, 1'b0},   // R5
      {1'b1, 8'h00, 1'b1, 1'b0, 8'h3F, 1'b0},   // R10 write wins
      {1'b0, 8'h00, 1'b1, 1'b0, 8'h3F, 1'b0},   // R4 low stage only
      {1'b1, 8'h40, 1'b0, 1'b0, 8'h7F, 1'b0},   // R6 lock set
      {1'b1, 8'h00, 1'b0, 1'b0, 8'h7F, 1'b0},   // R7 sticky
      {1'b1, 8'hC0, 1'b0, 1'b0, 8'hFF, 1'b0},   // R6
      {1'b0, 8'h00, 1'b1, 1'b0, 8'hFE, 1'b0},   // R5
      {1'b0, 8'h00, 1'b0, 1'b1, 8'h3F, 1'b1},   // R8 locked stop
      {1'b0, 8'h00, 1'b0, 1'b0, 8'h3F, 1'b1},   // R9
      {1'b1, 8'hC0, 1'b0, 1'b0, 8'h3F, 1'b1},   // R11 ignored
      {1'b0, 8'h00, 1'b0, 1'b0, 8'h3F, 1'b1},   // R9
      {1'b0, 8'h00, 1'b0, 1'b0, 8'h3F, 1'b0},   // R9 pulse over
      {1'b0, 8'h00, 1'b1, 1'b0, 8'h3F, 1'b0},   // R9 idle again
      {1'b0, 8'h00, 1'b0, 1'b1, 8'h3F, 1'b0},   // R8 unlocked stop
      {1'b1, 8'h00, 1'b0, 1'b0, 8'h3F, 1'b0},   // R3
      {1'b0, 8'h00, 1'b0, 1'b1, 8'h3F, 1'b0}    // R8 unlocked stop
   };

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > LIMIT) begin
         fails++;
         $display("FAIL watchdog: run hung, act=%0d cycles exp<=%0d", cycles, LIMIT);
         finish_run();
      end
   end

   task automatic check(string req, logic [7:0] act_rd, logic [7:0] exp_rd,
                        logic act_r, logic exp_r);
      checks++;
      if (act_rd !== exp_rd || act_r !== exp_r) begin
         fails++;
         $display("FAIL %s: act rdata=%h rst=%b exp rdata=%h rst=%b",
                  req, act_rd, act_r, exp_rd, exp_r);
      end
   endtask

   // Apply inputs for one edge; return at the following falling edge.
   task automatic cyc(logic we, logic [7:0] wd, logic en, logic stp);
      reg_we = we; reg_wdata = wd; cnt_en = en; stop_exec = stp;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = 8'h00; cnt_en = 1'b0; stop_exec = 1'b0;
   endtask

   task automatic run_en(int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 1'b1, 1'b0);
   endtask

   initial begin
      int hi_cnt;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset state", reg_rdata, 8'h3F, rst_req, 1'b0);

      for (int v = 0; v < NVEC; v++) begin
         cyc(VEC[v][19], VEC[v][18:11], VEC[v][10], VEC[v][9]);
         check($sformatf("vector %0d", v), reg_rdata, VEC[v][8:1], rst_req, VEC[v][0]);
      end

      // R1: asynchronous reset clears lock and source.
      cyc(1'b1, 8'hC0, 1'b0, 1'b0);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset after lock", reg_rdata, 8'h3F, rst_req, 1'b0);

      // R2: many enables with the timer idle.
      run_en(300);
      check("R2 idle after 300 enables", reg_rdata, 8'h3F, rst_req, 1'b0);

      // R4: cascaded timeout.
      cyc(1'b1, 8'h00, 1'b0, 1'b0);
      run_en(255);
      check("R4 after 255 enables", reg_rdata, 8'h3F, rst_req, 1'b0);
      run_en(1);
      check("R4 after 256 enables", reg_rdata, 8'h3E, rst_req, 1'b0);
      run_en(16383 - 256);
      check("R4 one enable before timeout", reg_rdata, 8'h00, rst_req, 1'b0);
      run_en(1);
      check("R4 timeout", reg_rdata, 8'h3F, rst_req, 1'b1);
      // R9: pulse length counted at the ports.
      hi_cnt = 1;
      for (int i = 0; i < 8; i++) begin
         cyc(1'b0, 8'h00, 1'b0, 1'b0);
         if (rst_req) hi_cnt++;
      end
      checks++;
      if (hi_cnt != 4) begin
         fails++;
         $display("FAIL R9 pulse length: act=%0d exp=%0d", hi_cnt, 4);
      end
      run_en(5);
      check("R9 idle after pulse", reg_rdata, 8'h3F, rst_req, 1'b0);

      // R5: direct timeout; R3 a late write restarts it.
      cyc(1'b1, 8'h80, 1'b0, 1'b0);
      run_en(40);
      check("R5 after 40 enables", reg_rdata, 8'h97, rst_req, 1'b0);
      cyc(1'b1, 8'h80, 1'b0, 1'b0);
      check("R3 restart", reg_rdata, 8'hBF, rst_req, 1'b0);
      run_en(63);
      check("R5 one before timeout", reg_rdata, 8'h80, rst_req, 1'b0);
      run_en(1);
      check("R5 timeout", reg_rdata, 8'h3F, rst_req, 1'b1);
      run_en(4);
      check("R9 after direct pulse", reg_rdata, 8'h3F, rst_req, 1'b0);

      finish_run();
   end

endmodule